// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry/Exit Sequencer

This block sits inside an SDRAM controller and takes the memory into and out of its low-power self-refresh state. When a sleep request arrives during normal operation, it waits until every bank has been reported idle for the precharge recovery time. It then issues the refresh command encoding in a cycle where the clock-enable pin is driven low. Clock-enable stays low for the whole sleep period, and the command pins carry only NOP, because the memory ignores them then.

A wake request may arrive early. It is then remembered until the minimum residency, counted from the entry cycle, has run out. Once that time has passed, the sequencer waits for the clock-stable indication before it drives clock-enable high again. It then issues NOP commands for the exit recovery window, whose length is a parameter with a floor of two cycles. When the window closes it reports ready, and it pulses a signal for one cycle that restarts the controller's refresh interval timer, so that a normal refresh follows soon after.

Top module: `sdram_selfref_seq`

## Requirements
- R1: While reset is applied and until ready is first reported, cke_o is high, cmd_o is NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), ready_o is low and asleep_o is low. After reset is released, ready_o rises within a few cycles.
- R2: A sleep request sampled while ready_o is high leads to exactly one cycle with cmd_o = 4'b0001 (refresh) and cke_o low. That cycle comes in the cycle after banks_idle_i has been sampled high on TRP_CYC consecutive cycles of the precharge wait. A low sample restarts that count.
- R3: cke_o is low from the entry cycle until the exit and high at all other times. asleep_o is high in every low cycle after the entry cycle. In every cycle other than the entry cycle, cmd_o is NOP.
- R4: cke_o stays low for at least TRAS_CYC+1 consecutive cycles. A wake request sampled in the entry cycle or during the sleep is held, and takes effect once TRAS_CYC low cycles (entry included) have elapsed.
- R5: cke_o rises only in the cycle after clk_stable_i was sampled high, and only after the residency and the wake conditions were both met.
- R6: After cke_o rises, cmd_o is NOP for exactly max(2, XSR_CYC) cycles with ready_o low. ready_o then rises.
- R7: ref_restart_o is high for exactly one cycle: the first cycle in which ready_o is high, both after reset and after each exit.
- R8: A sleep request outside the ready state, and a wake request outside the entry and sleep states, have no effect on any output.
- R9: banks_idle_i has no effect once the entry command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_req_i | input | 1 | Request to enter self refresh (sampled in ready state) |
| wake_req_i | input | 1 | Request to leave self refresh |
| clk_stable_i | input | 1 | Memory clock is within its timing limits |
| banks_idle_i | input | 1 | All banks are precharged |
| cke_o | output | 1 | Memory clock-enable pin |
| cmd_o | output | 4 | Command pins {cs_n, ras_n, cas_n, we_n} |
| ready_o | output | 1 | Normal operation may proceed |
| asleep_o | output | 1 | Memory is resident in self refresh |
| ref_restart_o | output | 1 | One-cycle pulse restarting the refresh interval timer |

## Verification
The bench builds two copies side by side: one with TRP_CYC=3, TRAS_CYC=5 and XSR_CYC=1, so that the exit floor of two cycles is in force, and one with XSR_CYC=4, where the parameter sets the window. These small values let a sweep cover every combination of idle-delay length, a bank-idle dropout inside the precharge count, a wake that comes before, at or after the residency limit, and a clock-stable signal that comes late. For every cycle of each run, the entry cycle, the clock-enable rise and the ready rise are computed arithmetically and compared.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_WAIT,
    ST_ENTER,
    ST_SELF_REF,
    ST_WAIT_CLK,
    ST_EXIT_NOP,
    ST_READY
  } srseq_state_e;

  // Command pin order {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP     = 4'b0111;
  localparam logic [3:0] CMD_REFRESH = 4'b0001;

  function automatic int unsigned at_least(input int unsigned v, input int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

endpackage

// File: rtl/srseq_rst_sync.sv
module srseq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/srseq_span_cnt.sv
// Saturating span counter: done_o once LIMIT increments have been taken.
module srseq_span_cnt #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int unsigned W = $clog2(LIMIT + 2);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != LIM_V));
    cnt_d  = clr_i ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LIM_V);
endmodule

// File: rtl/srseq_ctrl.sv
module srseq_ctrl
  import srseq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sleep_req_i,
  input  logic         wake_req_i,
  input  logic         clk_stable_i,
  input  logic         banks_idle_i,
  input  logic         pre_done_i,
  input  logic         res_done_i,
  input  logic         exit_done_i,
  output srseq_state_e state_o,
  output srseq_state_e nxt_o,
  output logic         pre_clr_o,
  output logic         pre_inc_o,
  output logic         res_clr_o,
  output logic         res_inc_o,
  output logic         exit_clr_o,
  output logic         exit_inc_o
);
  srseq_state_e state_q, state_d;
  logic         pend_q, pend_d;
  logic         in_sleep;

  assign in_sleep = (state_q == ST_ENTER) || (state_q == ST_SELF_REF);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     state_d = ST_READY;
      ST_READY:    if (sleep_req_i) state_d = ST_PRE_WAIT;
      ST_PRE_WAIT: if (banks_idle_i && pre_done_i) state_d = ST_ENTER;
      ST_ENTER:    state_d = ST_SELF_REF;
      ST_SELF_REF: if ((wake_req_i || pend_q) && res_done_i) state_d = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clk_stable_i) state_d = ST_EXIT_NOP;
      ST_EXIT_NOP: if (exit_done_i) state_d = ST_READY;
      default:     state_d = ST_IDLE;
    endcase
  end

  // A wake seen during entry or residency is remembered until it is acted on.
  always_comb begin
    pend_d = in_sleep && (state_d != ST_WAIT_CLK) && (pend_q || wake_req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    pre_inc_o  = (state_q == ST_PRE_WAIT) && banks_idle_i;
    pre_clr_o  = !pre_inc_o;
    res_inc_o  = in_sleep;
    res_clr_o  = !in_sleep;
    exit_inc_o = (state_q == ST_EXIT_NOP);
    exit_clr_o = !exit_inc_o;
  end

  assign state_o = state_q;
  assign nxt_o   = state_d;
endmodule

// File: rtl/srseq_pins.sv
module srseq_pins
  import srseq_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  srseq_state_e state_i,
  input  srseq_state_e nxt_i,
  output logic         cke_o,
  output logic [3:0]   cmd_o,
  output logic         ready_o,
  output logic         asleep_o,
  output logic         ref_restart_o
);
  logic restart_q, restart_d;

  always_comb begin
    cke_o    = 1'b1;
    cmd_o    = CMD_NOP;
    ready_o  = 1'b0;
    asleep_o = 1'b0;
    unique case (state_i)
      ST_ENTER: begin
        cke_o = 1'b0;
        cmd_o = CMD_REFRESH;
      end
      ST_SELF_REF, ST_WAIT_CLK: begin
        cke_o    = 1'b0;
        asleep_o = 1'b1;
      end
      ST_READY: ready_o = 1'b1;
      default: ;
    endcase
  end

  assign restart_d = (nxt_i == ST_READY) && (state_i != ST_READY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= restart_d;
  end

  assign ref_restart_o = restart_q;
endmodule

// File: rtl/sdram_selfref_seq.sv
module sdram_selfref_seq
  import srseq_pkg::*;
#(
  parameter int unsigned TRP_CYC  = 3,
  parameter int unsigned TRAS_CYC = 7,
  parameter int unsigned XSR_CYC  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       wake_req_i,
  input  logic       clk_stable_i,
  input  logic       banks_idle_i,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       ready_o,
  output logic       asleep_o,
  output logic       ref_restart_o
);
  localparam int unsigned TRP_EFF  = at_least(TRP_CYC, 1);
  localparam int unsigned TRAS_EFF = at_least(TRAS_CYC, 2);
  localparam int unsigned XSR_EFF  = at_least(XSR_CYC, 2);

  logic         rst_n;
  srseq_state_e state, nxt;
  logic pre_clr, pre_inc, pre_done;
  logic res_clr, res_inc, res_done;
  logic exit_clr, exit_inc, exit_done;

  srseq_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  srseq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .sleep_req_i  (sleep_req_i),
    .wake_req_i   (wake_req_i),
    .clk_stable_i (clk_stable_i),
    .banks_idle_i (banks_idle_i),
    .pre_done_i   (pre_done),
    .res_done_i   (res_done),
    .exit_done_i  (exit_done),
    .state_o      (state),
    .nxt_o        (nxt),
    .pre_clr_o    (pre_clr),
    .pre_inc_o    (pre_inc),
    .res_clr_o    (res_clr),
    .res_inc_o    (res_inc),
    .exit_clr_o   (exit_clr),
    .exit_inc_o   (exit_inc)
  );

  // Idle run inside the precharge wait: TRP_EFF samples, current one included.
  srseq_span_cnt #(.LIMIT(TRP_EFF - 1)) u_pre_cnt (
    .clk_i (clk_i), .rst_ni (rst_n),
    .clr_i (pre_clr), .inc_i (pre_inc), .done_o (pre_done)
  );

  // Residency counted from the entry cycle.
  srseq_span_cnt #(.LIMIT(TRAS_EFF - 1)) u_res_cnt (
    .clk_i (clk_i), .rst_ni (rst_n),
    .clr_i (res_clr), .inc_i (res_inc), .done_o (res_done)
  );

  // NOP-only recovery window after clock-enable rises.
  srseq_span_cnt #(.LIMIT(XSR_EFF - 1)) u_exit_cnt (
    .clk_i (clk_i), .rst_ni (rst_n),
    .clr_i (exit_clr), .inc_i (exit_inc), .done_o (exit_done)
  );

  srseq_pins u_pins (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .state_i       (state),
    .nxt_i         (nxt),
    .cke_o         (cke_o),
    .cmd_o         (cmd_o),
    .ready_o       (ready_o),
    .asleep_o      (asleep_o),
    .ref_restart_o (ref_restart_o)
  );
endmodule

// File: rtl/srseq_sva.sv
module srseq_sva
  import srseq_pkg::*;
#(
  parameter int unsigned TRAS_CYC = 7,
  parameter int unsigned XSR_CYC  = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_stable_i,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic       ready_o,
  input logic       asleep_o,
  input logic       ref_restart_o
);
  localparam int unsigned TRAS_EFF = at_least(TRAS_CYC, 2);
  localparam int unsigned XSR_EFF  = at_least(XSR_CYC, 2);
  localparam int unsigned LW = $clog2(TRAS_EFF + 3);
  localparam int unsigned HW = $clog2(XSR_EFF + 2);
  localparam logic [LW-1:0] LOW_SAT = LW'(TRAS_EFF + 1);
  localparam logic [HW-1:0] HI_SAT  = HW'(XSR_EFF);

  logic          prev_cke_q, prev_ready_q, stable_q, slept_q;
  logic [LW-1:0] low_run_q;
  logic [HW-1:0] hi_run_q;
  logic          cke_rise, ready_rise;

  assign cke_rise   = cke_o && !prev_cke_q;
  assign ready_rise = ready_o && !prev_ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_cke_q   <= 1'b1;
      prev_ready_q <= 1'b0;
      stable_q     <= 1'b0;
      slept_q      <= 1'b0;
      low_run_q    <= '0;
      hi_run_q     <= '0;
    end else begin
      prev_cke_q   <= cke_o;
      prev_ready_q <= ready_o;
      stable_q     <= clk_stable_i;
      if (!cke_o)       slept_q <= 1'b1;
      else if (ready_o) slept_q <= 1'b0;
      if (cke_o)                   low_run_q <= '0;
      else if (low_run_q != LOW_SAT) low_run_q <= low_run_q + LW'(1);
      if (!cke_o)                 hi_run_q <= '0;
      else if (hi_run_q != HI_SAT) hi_run_q <= hi_run_q + HW'(1);
    end
  end

  a_r2_entry_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REFRESH) |-> !cke_o);

  a_r3_asleep_cke_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_o |-> !cke_o);

  a_r3_not_ready_asleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && asleep_o));

  a_r4_min_residency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_rise |-> (low_run_q >= LW'(TRAS_EFF + 1)));

  a_r5_stable_before_cke: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_rise |-> stable_q);

  a_r6_nop_in_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && !ready_o) |-> (cmd_o == CMD_NOP));

  a_r6_recovery_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_rise && slept_q) |-> (hi_run_q == HI_SAT));

  a_r7_restart_on_ready_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_restart_o |-> ready_rise);

  a_r7_ready_rise_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_rise |-> ref_restart_o);
endmodule

bind sdram_selfref_seq srseq_sva #(
  .TRAS_CYC (TRAS_CYC),
  .XSR_CYC  (XSR_CYC)
) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_stable_i  (clk_stable_i),
  .cke_o         (cke_o),
  .cmd_o         (cmd_o),
  .ready_o       (ready_o),
  .asleep_o      (asleep_o),
  .ref_restart_o (ref_restart_o)
);

// File: tb/sdram_selfref_seq_test.sv
module sdram_selfref_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRP  = 3;
  localparam int TRAS = 5;
  localparam int XA   = 2;   // XSR_CYC=1 clamped to 2
  localparam int XB   = 4;
  localparam int MAX_CYCLES = 150000;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1, banks_idle = 1'b1;
  logic       cke_a, rdy_a, slp_a, rst_a;
  logic [3:0] cmd_a;
  logic       cke_b, rdy_b, slp_b, rst_b;
  logic [3:0] cmd_b;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_selfref_seq #(.TRP_CYC(TRP), .TRAS_CYC(TRAS), .XSR_CYC(1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .clk_stable_i(clk_stable), .banks_idle_i(banks_idle), .cke_o(cke_a), .cmd_o(cmd_a),
    .ready_o(rdy_a), .asleep_o(slp_a), .ref_restart_o(rst_a));

  sdram_selfref_seq #(.TRP_CYC(TRP), .TRAS_CYC(TRAS), .XSR_CYC(XB)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .wake_req_i(wake_req),
    .clk_stable_i(clk_stable), .banks_idle_i(banks_idle), .cke_o(cke_b), .cmd_o(cmd_b),
    .ready_o(rdy_b), .asleep_o(slp_b), .ref_restart_o(rst_b));

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_cycle(input string who, input int i, input int e, input int r, input int x,
                             input logic cke, input logic [3:0] cmd, input logic rdy,
                             input logic slp, input logic rs);
    check($sformatf("R2/R3 cmd %s cyc %0d", who, i), cmd, (i == e) ? REF : NOP);
    check($sformatf("R3/R4/R5/R9 cke %s cyc %0d", who, i), cke, !(i >= e && i < r));
    check($sformatf("R3 asleep %s cyc %0d", who, i), slp, (i > e && i < r));
    check($sformatf("R6 ready %s cyc %0d", who, i), rdy, (i == 0) || (i >= r + x));
    check($sformatf("R7 restart %s cyc %0d", who, i), rs, (i == r + x));
  endtask

  task automatic check_idle_ready(input string tag);
    check({tag, " cke a"}, cke_a, 1);   check({tag, " cke b"}, cke_b, 1);
    check({tag, " rdy a"}, rdy_a, 1);   check({tag, " rdy b"}, rdy_b, 1);
    check({tag, " cmd a"}, cmd_a, NOP); check({tag, " slp a"}, slp_a, 0);
  endtask

  // One sleep/wake episode; d: idle delay, g: idle samples before a dropout (0 = none),
  // w: wake offset from entry, s: extra clock-stable delay (3 also sends a stray wake).
  task automatic episode(input int d, input int g, input int w, input int s);
    int e, c, t, r, n;
    e = (g > 0) ? d + g + TRP + 2 : d + TRP + 1;
    c = (e + TRAS - 1 > e + w) ? e + TRAS - 1 : e + w;
    t = (c + 1 > e + w + s) ? c + 1 : e + w + s;
    r = t + 1;
    n = r + XB + 1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      check_cycle("A", i, e, r, XA, cke_a, cmd_a, rdy_a, slp_a, rst_a);
      check_cycle("B", i, e, r, XB, cke_b, cmd_b, rdy_b, slp_b, rst_b);
      // R8: stray sleep during residency, stray wake during precharge wait
      sleep_req  = (i == 0) || ((w % 2 == 1) && i == e + 1);
      wake_req   = (i == e + w) || (s == 3 && i == 1);
      // R9: banks_idle dropout right after entry
      banks_idle = !((i <= d) || (g > 0 && i == d + g + 1) || (i == e + 1));
      clk_stable = (i >= e + w + s);
    end
    @(negedge clk);
    sleep_req = 0; wake_req = 0; banks_idle = 1; clk_stable = 1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc >= MAX_CYCLES);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL all requirements: watchdog got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int waited;
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 reset cke a", cke_a, 1);   check("R1 reset cmd a", cmd_a, NOP);
      check("R1 reset rdy a", rdy_a, 0);   check("R1 reset slp a", slp_a, 0);
      check("R1 reset rdy b", rdy_b, 0);   check("R1 reset rst a", rst_a, 0);
    end
    rst_n = 1;
    waited = 0;
    while (!rdy_a && waited < 10) begin
      @(negedge clk);
      waited++;
      if (!rdy_a) begin
        check("R1 pre-ready cke", cke_a, 1);
        check("R1 pre-ready cmd", cmd_a, NOP);
      end
    end
    check("R1 ready after reset", rdy_a, 1);
    check("R7 restart after reset a", rst_a, 1);
    check("R7 restart after reset b", rst_b, 1);
    @(negedge clk);
    check("R7 restart single pulse", rst_a, 0);

    // R8: wake while ready has no effect
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_idle_ready("R8 wake in ready");
    end

    for (int d = 0; d < 3; d++)
      for (int g = 0; g < 3; g++)
        for (int w = 0; w < 8; w++)
          for (int s = 0; s < 4; s++)
            episode(d, g, w, s);

    // R8: after the sweep, another stray wake in ready
    wake_req = 1;
    @(negedge clk);
    wake_req = 0;
    @(negedge clk);
    check_idle_ready("R8 final wake in ready");

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule